// File: doc/BRIEF.md
# Frame Latency Output Scheduler

This block decides when processed radar frames may leave the processor. A free-running cycle counter provides the time base. Each time the final input pulse of a frame is flagged, the counter value is stored in a small circular store of arrival stamps. Once a run is armed, the scheduler takes the oldest stored stamp and waits until the time elapsed since that stamp is strictly greater than a programmed latency. It then empties the output FIFOs for that frame, one polarization channel at a time: first the header words, then the image words.

The FIFOs themselves live outside the block. The scheduler sees only one empty flag per FIFO and drives one read strobe per FIFO. It issues a read only when the addressed FIFO has data. When the FIFO is empty it holds its position until data appears. A small command port is used to arm a run. Configuration load commands mark which required settings have been delivered. A single-step command arms one frame, and a counted step command arms between one and five frames. Both are refused until every load has arrived.

When the last armed frame has been emitted, the run flag falls and a one-cycle completion pulse is produced.

Top module: `frame_latency_sched`

## Requirements
- R1: On every cycle where `last_pulse` is high, the current counter value is stored as the arrival stamp of a new frame. At most five stamps can be pending. A `last_pulse` that arrives while five are pending is discarded, and that frame is never emitted.
- R2: While `run` is low, no bit of `hdr_rd` or `img_rd` is ever asserted.
- R3: The first read for a frame happens only after the counter value minus the frame's stamp is strictly greater than `lat_cycles`. If the scheduler is already waiting and data is available, that first read appears exactly `lat_cycles`+2 cycles after the cycle in which `last_pulse` was high.
- R4: A frame is emitted channel by channel in ascending index order. Each enabled channel p gets exactly HDR_WORDS strobes on `hdr_rd[p]`, then exactly IMG_WORDS strobes on `img_rd[p]`, before the next channel starts. At most one strobe bit is high in any cycle.
- R5: `pol_en` bit p enables channel p. It is sampled when a frame is released. A channel whose bit is 0 gets no strobes and costs no cycles. With all bits 0, the frame completes in the cycle after it becomes eligible, with no reads at all.
- R6: A read strobe is never asserted for a FIFO whose empty flag is high. While the flag stays high, the read position holds.
- R7: Frames are emitted in arrival order. A later frame's first read comes no earlier than both its own latency expiry (R3) and two cycles after the previous frame's final read.
- R8: The command opcode on `cmd_op` selects the action: 1 = load (`cmd_arg` gives the load index 0..2), 2 = single step, 3 = counted step (`cmd_arg` = frame count). When all three loads have been seen, a single step arms 1 frame and a counted step with a count of 1..5 arms that many frames. In both cases `run` is high in the cycle after the command is sampled. Loads stay recorded across runs.
- R9: The following commands are rejected: a step before all loads have arrived, a step while `run` is high, a counted step with a count of 0 or above 5, and a load index above 2. A rejected command raises `cmd_err` for exactly the one following cycle and leaves `run` unchanged.
- R10: In the cycle after the final read of the last armed frame, `run` is low and `done` is high. `done` is high for that single cycle only.
- R11: The elapsed-time comparison uses modular subtraction, so R3 timing holds unchanged when the counter wraps between a frame's stamp and its release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Opcode: 0 none, 1 load, 2 single step, 3 counted step |
| cmd_arg | input | ARG_W | Load index or frame count |
| lat_cycles | input | TS_W | Required latency in cycles (strictly exceeded) |
| pol_en | input | NUM_POL | Channel enable mask |
| last_pulse | input | 1 | Final pulse of a frame received this cycle |
| hdr_empty | input | NUM_POL | Header FIFO empty, per channel |
| img_empty | input | NUM_POL | Image FIFO empty, per channel |
| hdr_rd | output | NUM_POL | Header FIFO read strobe, per channel |
| img_rd | output | NUM_POL | Image FIFO read strobe, per channel |
| run | output | 1 | Run armed and frames remain |
| done | output | 1 | One-cycle pulse when the last armed frame finishes |
| cmd_err | output | 1 | One-cycle pulse after a rejected command |

## Verification
Some properties are checked by assertions on every cycle:
- The stamp store never holds more than five entries and is never popped while empty.
- No strobe appears while the run flag is low.
- A stalled FIFO freezes the channel and word position.
- A release out of the waiting state always follows a cycle in which the latency was exceeded.
- The completion pulse lasts one cycle and never coincides with an active run.
- An early step is always refused.

Other behaviour needs the bench's scenarios to be seen. These are the exact release cycle for each frame, the exact word and channel order, the discarding of a sixth queued frame, the cycles with an empty mask, and release timing that stays correct across counter wraparound over long random runs.

// File: rtl/fls_pkg.sv
package fls_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_STEPN = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_WAIT = 2'd1,
        DR_HDR  = 2'd2,
        DR_IMG  = 2'd3
    } drain_st_e;

endpackage

// File: rtl/fls_cmd.sv
module fls_cmd #(
    parameter int NUM_LOADS  = 3,
    parameter int MAX_FRAMES = 5,
    parameter int ARG_W      = 8,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic             busy,
    output logic             arm,
    output logic [CNT_W-1:0] arm_count,
    output logic             err
);
    import fls_pkg::*;

    typedef struct packed {
        logic [NUM_LOADS-1:0] loaded;
        logic                 err;
    } cmd_state_t;

    cmd_state_t cur_q, nxt_d;
    logic       all_loaded;
    logic       count_ok;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.err  = 1'b0;
        arm        = 1'b0;
        arm_count  = '0;
        all_loaded = &cur_q.loaded;
        count_ok   = (cmd_arg != '0) && (cmd_arg <= ARG_W'(MAX_FRAMES));
        if (cmd_valid) begin
            case (cmd_op_e'(cmd_op))
                OP_LOAD: begin
                    if (cmd_arg < ARG_W'(NUM_LOADS)) begin
                        for (int i = 0; i < NUM_LOADS; i++) begin
                            if (cmd_arg == ARG_W'(i)) nxt_d.loaded[i] = 1'b1;
                        end
                    end else begin
                        nxt_d.err = 1'b1;
                    end
                end
                OP_STEP: begin
                    if (all_loaded && !busy) begin
                        arm       = 1'b1;
                        arm_count = CNT_W'(1);
                    end else begin
                        nxt_d.err = 1'b1;
                    end
                end
                OP_STEPN: begin
                    if (all_loaded && !busy && count_ok) begin
                        arm       = 1'b1;
                        arm_count = CNT_W'(cmd_arg);
                    end else begin
                        nxt_d.err = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign err = cur_q.err;

    AST_EARLY_STEP_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && !(&cur_q.loaded)) |=> err); // R9

    AST_ARM_AFTER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (&cur_q.loaded && !busy)); // R8

endmodule

// File: rtl/fls_ts_ring.sv
module fls_ts_ring #(
    parameter int DEPTH = 5,
    parameter int TS_W  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic [TS_W-1:0] now,
    output logic [TS_W-1:0] head,
    output logic            head_valid
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [TS_W-1:0]  now;
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [OCC_W-1:0] occ;
    } ring_state_t;

    ring_state_t     cur_q, nxt_d;
    logic            accept;
    logic            take;
    logic [TS_W-1:0] slot_view [DEPTH];

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.now = cur_q.now + TS_W'(1);
        accept    = push && (cur_q.occ != OCC_W'(DEPTH));
        take      = pop && (cur_q.occ != '0);
        if (accept) nxt_d.wr = wrap_inc(cur_q.wr);
        if (take)   nxt_d.rd = wrap_inc(cur_q.rd);
        case ({accept, take})
            2'b10:   nxt_d.occ = cur_q.occ + OCC_W'(1);
            2'b01:   nxt_d.occ = cur_q.occ - OCC_W'(1);
            default: nxt_d.occ = cur_q.occ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [TS_W-1:0] slot_d, slot_q;
        always_comb slot_d = (accept && cur_q.wr == PTR_W'(g)) ? cur_q.now : slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end
        assign slot_view[g] = slot_q;
    end

    assign now        = cur_q.now;
    assign head       = slot_view[cur_q.rd];
    assign head_valid = (cur_q.occ != '0);

    AST_STAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.occ <= OCC_W'(DEPTH)); // R1

    AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cur_q.occ != '0); // R7

endmodule

// File: rtl/fls_drain.sv
module fls_drain #(
    parameter int NUM_POL   = 4,
    parameter int HDR_WORDS = 4,
    parameter int IMG_WORDS = 16,
    parameter int TS_W      = 32,
    parameter int CNT_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [CNT_W-1:0]   arm_count,
    input  logic [NUM_POL-1:0] pol_en,
    input  logic [TS_W-1:0]    lat,
    input  logic [TS_W-1:0]    now,
    input  logic [TS_W-1:0]    head,
    input  logic               head_valid,
    input  logic [NUM_POL-1:0] hdr_empty,
    input  logic [NUM_POL-1:0] img_empty,
    output logic [NUM_POL-1:0] hdr_rd,
    output logic [NUM_POL-1:0] img_rd,
    output logic               pop,
    output logic               run,
    output logic               done
);
    import fls_pkg::*;

    localparam int POL_W  = (NUM_POL > 1) ? $clog2(NUM_POL) : 1;
    localparam int MAXW   = (HDR_WORDS > IMG_WORDS) ? HDR_WORDS : IMG_WORDS;
    localparam int WORD_W = $clog2(MAXW + 1);

    typedef struct packed {
        drain_st_e          st;
        logic [POL_W-1:0]   pol;
        logic [WORD_W-1:0]  word;
        logic [CNT_W-1:0]   left;
        logic [NUM_POL-1:0] mask;
        logic               run;
        logic               done;
    } drain_state_t;

    drain_state_t    cur_q, nxt_d;
    logic [TS_W-1:0] elapsed;
    logic            eligible;
    logic            strobe;
    logic [POL_W:0]  pick;

    function automatic logic [POL_W:0] next_pol(input logic [NUM_POL-1:0] m, input int from);
        logic [POL_W:0] res;
        res = '0;
        for (int i = NUM_POL - 1; i >= 0; i--) begin
            if (i >= from && m[i]) res = {1'b1, POL_W'(i)};
        end
        return res;
    endfunction

    always_comb begin
        elapsed  = now - head;
        eligible = head_valid && (elapsed > lat);
        hdr_rd   = '0;
        img_rd   = '0;
        if (cur_q.st == DR_HDR && !hdr_empty[cur_q.pol]) hdr_rd[cur_q.pol] = 1'b1;
        if (cur_q.st == DR_IMG && !img_empty[cur_q.pol]) img_rd[cur_q.pol] = 1'b1;
        strobe = (|hdr_rd) || (|img_rd);
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        pop        = 1'b0;
        pick       = '0;
        case (cur_q.st)
            DR_IDLE: begin
                if (arm) begin
                    nxt_d.run  = 1'b1;
                    nxt_d.left = arm_count;
                    nxt_d.st   = DR_WAIT;
                end
            end
            DR_WAIT: begin
                if (eligible) begin
                    nxt_d.mask = pol_en;
                    pick       = next_pol(pol_en, 0);
                    if (pick[POL_W]) begin
                        nxt_d.st   = DR_HDR;
                        nxt_d.pol  = pick[POL_W-1:0];
                        nxt_d.word = '0;
                    end else begin
                        pop = 1'b1;
                    end
                end
            end
            DR_HDR: begin
                if (strobe) begin
                    if (cur_q.word == WORD_W'(HDR_WORDS - 1)) begin
                        nxt_d.word = '0;
                        nxt_d.st   = DR_IMG;
                    end else begin
                        nxt_d.word = cur_q.word + WORD_W'(1);
                    end
                end
            end
            DR_IMG: begin
                if (strobe) begin
                    if (cur_q.word == WORD_W'(IMG_WORDS - 1)) begin
                        nxt_d.word = '0;
                        pick       = next_pol(cur_q.mask, int'(cur_q.pol) + 1);
                        if (pick[POL_W]) begin
                            nxt_d.st  = DR_HDR;
                            nxt_d.pol = pick[POL_W-1:0];
                        end else begin
                            pop = 1'b1;
                        end
                    end else begin
                        nxt_d.word = cur_q.word + WORD_W'(1);
                    end
                end
            end
            default: nxt_d.st = DR_IDLE;
        endcase
        if (pop) begin
            if (cur_q.left == CNT_W'(1)) begin
                nxt_d.left = '0;
                nxt_d.run  = 1'b0;
                nxt_d.done = 1'b1;
                nxt_d.st   = DR_IDLE;
            end else begin
                nxt_d.left = cur_q.left - CNT_W'(1);
                nxt_d.st   = DR_WAIT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= DR_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign run  = cur_q.run;
    assign done = cur_q.done;

    AST_SILENT_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.run |-> (hdr_rd == '0 && img_rd == '0)); // R2

    AST_RELEASE_AFTER_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == DR_HDR && $past(cur_q.st) == DR_WAIT) |-> $past(elapsed > lat)); // R3

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_rd, img_rd})); // R4

    AST_STROBE_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((hdr_rd | img_rd) & ~cur_q.mask) == '0); // R5

    AST_HOLD_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == DR_HDR && hdr_empty[cur_q.pol])
        |=> (cur_q.st == DR_HDR && $stable(cur_q.pol) && $stable(cur_q.word))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !run); // R10

endmodule

// File: rtl/frame_latency_sched.sv
module frame_latency_sched #(
    parameter int TS_W       = 32,
    parameter int NUM_POL    = 4,
    parameter int HDR_WORDS  = 4,
    parameter int IMG_WORDS  = 16,
    parameter int RING_DEPTH = 5,
    parameter int NUM_LOADS  = 3,
    parameter int ARG_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [ARG_W-1:0]   cmd_arg,
    input  logic [TS_W-1:0]    lat_cycles,
    input  logic [NUM_POL-1:0] pol_en,
    input  logic               last_pulse,
    input  logic [NUM_POL-1:0] hdr_empty,
    input  logic [NUM_POL-1:0] img_empty,
    output logic [NUM_POL-1:0] hdr_rd,
    output logic [NUM_POL-1:0] img_rd,
    output logic               run,
    output logic               done,
    output logic               cmd_err
);
    localparam int CNT_W = $clog2(RING_DEPTH + 1);

    logic             arm;
    logic [CNT_W-1:0] arm_count;
    logic             pop;
    logic [TS_W-1:0]  now;
    logic [TS_W-1:0]  head;
    logic             head_valid;

    fls_cmd #(
        .NUM_LOADS (NUM_LOADS),
        .MAX_FRAMES(RING_DEPTH),
        .ARG_W     (ARG_W),
        .CNT_W     (CNT_W)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_arg  (cmd_arg),
        .busy     (run),
        .arm      (arm),
        .arm_count(arm_count),
        .err      (cmd_err)
    );

    fls_ts_ring #(
        .DEPTH(RING_DEPTH),
        .TS_W (TS_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (last_pulse),
        .pop       (pop),
        .now       (now),
        .head      (head),
        .head_valid(head_valid)
    );

    fls_drain #(
        .NUM_POL  (NUM_POL),
        .HDR_WORDS(HDR_WORDS),
        .IMG_WORDS(IMG_WORDS),
        .TS_W     (TS_W),
        .CNT_W    (CNT_W)
    ) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .arm_count (arm_count),
        .pol_en    (pol_en),
        .lat       (lat_cycles),
        .now       (now),
        .head      (head),
        .head_valid(head_valid),
        .hdr_empty (hdr_empty),
        .img_empty (img_empty),
        .hdr_rd    (hdr_rd),
        .img_rd    (img_rd),
        .pop       (pop),
        .run       (run),
        .done      (done)
    );

endmodule

// File: tb/frame_latency_sched_test.sv
module frame_latency_sched_test;
    localparam int TS_W = 10;
    localparam int NP   = 4;
    localparam int HW   = 2;
    localparam int IW   = 5;
    localparam int AW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_arg = '0;
    logic [TS_W-1:0] lat_cycles = '0;
    logic [NP-1:0] pol_en = '0;
    logic          last_pulse = 1'b0;
    logic [NP-1:0] hdr_empty = '0;
    logic [NP-1:0] img_empty = '0;
    logic [NP-1:0] hdr_rd, img_rd;
    logic          run, done, cmd_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit stall  = 1'b0;
    bit finished = 1'b0;

    int ev_cyc[$];
    int ev_code[$];
    int lp_cyc[$];
    int done_cyc[$];

    frame_latency_sched #(
        .TS_W(TS_W), .NUM_POL(NP), .HDR_WORDS(HW), .IMG_WORDS(IW),
        .RING_DEPTH(5), .NUM_LOADS(3), .ARG_W(AW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .lat_cycles(lat_cycles), .pol_en(pol_en),
        .last_pulse(last_pulse), .hdr_empty(hdr_empty), .img_empty(img_empty),
        .hdr_rd(hdr_rd), .img_rd(img_rd), .run(run), .done(done), .cmd_err(cmd_err)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int popc(input logic [NP-1:0] m);
        int n = 0;
        for (int i = 0; i < NP; i++) if (m[i]) n++;
        return n;
    endfunction

    always @(posedge clk) begin
        #1;
        for (int p = 0; p < NP; p++) begin
            hdr_empty[p] = stall ? ($urandom_range(99) < 30) : 1'b0;
            img_empty[p] = stall ? ($urandom_range(99) < 30) : 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (last_pulse) lp_cyc.push_back(cyc);
            if (done) begin
                done_cyc.push_back(cyc);
                chk(run == 1'b0, "R10", "run low during done", int'(run), 0);
            end
            if ((|hdr_rd) || (|img_rd)) begin
                int code = 0;
                chk($countones({hdr_rd, img_rd}) == 1, "R4", "single strobe", $countones({hdr_rd, img_rd}), 1);
                chk(((hdr_rd & hdr_empty) | (img_rd & img_empty)) == '0, "R6", "read of empty fifo",
                    int'((hdr_rd & hdr_empty) | (img_rd & img_empty)), 0);
                chk(run == 1'b1, "R2", "strobe while stopped", int'(run), 1);
                for (int p = 0; p < NP; p++) begin
                    if (hdr_rd[p]) code = p;
                    if (img_rd[p]) code = NP + p;
                end
                ev_cyc.push_back(cyc);
                ev_code.push_back(code);
            end
        end
    end

    task automatic step_cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic send_cmd(input logic [1:0] op, input int arg);
        step_cyc();
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = AW'(arg);
        step_cyc();
        cmd_valid = 1'b0;
        cmd_op    = 2'd0;
        cmd_arg   = '0;
    endtask

    task automatic expect_err(input string what, input bit run_exp);
        @(negedge clk);
        chk(cmd_err == 1'b1, "R9", what, int'(cmd_err), 1);
        chk(run == run_exp, "R9", {what, " run unchanged"}, int'(run), int'(run_exp));
        @(negedge clk);
        chk(cmd_err == 1'b0, "R9", {what, " pulse width"}, int'(cmd_err), 0);
        #1;
    endtask

    task automatic pulse();
        step_cyc();
        last_pulse = 1'b1;
        step_cyc();
        last_pulse = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        int n0 = done_cyc.size();
        int k = 0;
        while (done_cyc.size() == n0 && k < limit) begin
            @(negedge clk);
            k++;
        end
        chk(done_cyc.size() == n0 + 1, "R10", "done pulse seen", done_cyc.size(), n0 + 1);
        #1;
    endtask

    task automatic check_run(input int nfr, input logic [NP-1:0] mask, input int arm_c, input int lat, input bit exact);
        int k_words = popc(mask) * (HW + IW);
        int prev = arm_c - 1;
        int prev_done = arm_c;
        int mism = 0;
        int idx = 0;
        chk(ev_cyc.size() == nfr * k_words, "R4", "total reads", ev_cyc.size(), nfr * k_words);
        chk(lp_cyc.size() >= nfr, "R1", "stamped frames", lp_cyc.size(), nfr);
        if (ev_cyc.size() == nfr * k_words && lp_cyc.size() >= nfr) begin
            for (int f = 0; f < nfr; f++)
                for (int p = 0; p < NP; p++)
                    if (mask[p]) begin
                        for (int w = 0; w < HW; w++) begin
                            if (ev_code[idx] != p) mism++;
                            idx++;
                        end
                        for (int w = 0; w < IW; w++) begin
                            if (ev_code[idx] != NP + p) mism++;
                            idx++;
                        end
                    end
            chk(mism == 0, "R4", "channel/word order mismatches", mism, 0);
            for (int f = 0; f < nfr; f++) begin
                int bound = lp_cyc[f] + lat + 2;
                if (k_words > 0) begin
                    int st = ev_cyc[f * k_words];
                    int ex = (bound > prev + 2) ? bound : prev + 2;
                    if (exact) chk(st == ex, "R7", "frame release cycle", st, ex);
                    else       chk(st >= bound, "R11", "release not before latency (R3)", st, bound);
                    prev = ev_cyc[f * k_words + k_words - 1];
                end else begin
                    prev_done = (bound > prev_done + 1) ? bound : prev_done + 1;
                    prev = prev_done - 1;
                end
            end
            if (done_cyc.size() > 0)
                chk(done_cyc[done_cyc.size() - 1] == prev + 1, "R10", "done cycle", done_cyc[done_cyc.size() - 1], prev + 1);
        end
        ev_cyc.delete();
        ev_code.delete();
        for (int f = 0; f < nfr && lp_cyc.size() > 0; f++) void'(lp_cyc.pop_front());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int arm_c;
        void'($urandom(32'h5A17C0DE));
        repeat (5) step_cyc();
        rst_n = 1'b1;
        @(negedge clk);
        chk(run == 1'b0 && done == 1'b0 && cmd_err == 1'b0, "R2", "reset outputs", int'({run, done, cmd_err}), 0);
        chk(hdr_rd == '0 && img_rd == '0, "R2", "reset strobes", int'({hdr_rd, img_rd}), 0);
        #1;

        // R9: commands refused before loads complete
        send_cmd(2'd2, 0);
        expect_err("step before loads", 1'b0);
        send_cmd(2'd1, 0);
        send_cmd(2'd1, 1);
        send_cmd(2'd3, 2);
        expect_err("counted step with load missing", 1'b0);
        send_cmd(2'd1, 7);
        expect_err("load index out of range", 1'b0);
        send_cmd(2'd1, 2);

        // R8 / R3: single step, all channels, exact release
        lat_cycles = TS_W'(20);
        pol_en = 4'b1111;
        send_cmd(2'd2, 0);
        arm_c = cyc;
        @(negedge clk);
        chk(run == 1'b1, "R8", "run after step", int'(run), 1);
        repeat (10) step_cyc();
        chk(ev_cyc.size() == 0, "R3", "no reads before any frame stamp", ev_cyc.size(), 0);
        pulse();
        wait_done(500);
        check_run(1, 4'b1111, arm_c, 20, 1'b1);

        // R9: bad counts
        send_cmd(2'd3, 0);
        expect_err("count zero", 1'b0);
        send_cmd(2'd3, 6);
        expect_err("count six", 1'b0);

        // R7 / R5: three frames, sparse mask, step while running
        lat_cycles = TS_W'(15);
        pol_en = 4'b1010;
        send_cmd(2'd3, 3);
        arm_c = cyc;
        send_cmd(2'd2, 0);
        expect_err("step while running", 1'b1);
        repeat (3) begin
            pulse();
            repeat (3) step_cyc();
        end
        wait_done(1000);
        check_run(3, 4'b1010, arm_c, 15, 1'b1);

        // R5: empty mask, zero latency
        lat_cycles = '0;
        pol_en = 4'b0000;
        send_cmd(2'd2, 0);
        arm_c = cyc;
        pulse();
        wait_done(100);
        check_run(1, 4'b0000, arm_c, 0, 1'b1);

        // R1: six stamps before arming, sixth discarded
        lat_cycles = TS_W'(5);
        pol_en = 4'b0001;
        repeat (6) pulse();
        repeat (2) step_cyc();
        chk(lp_cyc.size() == 6, "R1", "pulses seen", lp_cyc.size(), 6);
        void'(lp_cyc.pop_back());
        send_cmd(2'd3, 5);
        arm_c = cyc;
        wait_done(1000);
        check_run(5, 4'b0001, arm_c, 5, 1'b1);
        send_cmd(2'd2, 0);
        arm_c = cyc;
        repeat (60) step_cyc();
        chk(ev_cyc.size() == 0, "R1", "discarded frame not emitted", ev_cyc.size(), 0);
        chk(run == 1'b1, "R1", "still waiting for a frame", int'(run), 1);
        pulse();
        wait_done(200);
        check_run(1, 4'b0001, arm_c, 5, 1'b1);

        // Random runs with FIFO stalls; counter wraps several times (R11)
        stall = 1'b1;
        for (int r = 0; r < 14; r++) begin
            int n = $urandom_range(1, 5);
            int lat = $urandom_range(0, 150);
            logic [NP-1:0] m = NP'($urandom_range(1, 15));
            lat_cycles = TS_W'(lat);
            pol_en = m;
            if (n == 1 && $urandom_range(1) == 1) send_cmd(2'd2, 0);
            else send_cmd(2'd3, n);
            arm_c = cyc;
            for (int f = 0; f < n; f++) begin
                repeat ($urandom_range(0, 25)) step_cyc();
                pulse();
            end
            wait_done(4000);
            check_run(n, m, arm_c, lat, 1'b0);
        end
        stall = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule